// File: doc/BRIEF.md
# I2C Target Controller

This block answers on an I2C bus as a target device. It watches the serial clock and data lines through synchronisers and detects START, repeated START and STOP conditions. It compares each address byte with a programmed 7-bit own address and can also accept the general-call address. Once it is addressed, it either takes bytes from the bus controller or shifts bytes out to it. Both lines are open-drain: the block only ever pulls a line low, through an output-enable.

Software sees five byte-wide registers on a simple write/read port. A status register and an interrupt-enable register share one bit layout, and the interrupt output is raised whenever an enabled status bit is set. Each bus event sets a status flag. Software clears a flag by writing a zero to its bit. Received and outgoing bytes pass through one shared data register. While a received byte or a request for an outgoing byte is waiting for software, the block holds the clock line low so the bus controller cannot advance. A control bit makes the block answer a received byte with NACK instead of ACK.

Top module: `i2ct_top`

## Requirements
- R1: With the enable bit (control bit 2) set, an address byte whose upper seven bits equal own-address bits 6:0 is acknowledged and sets status bit 0. Any other address is not acknowledged and sets no flag.
- R2: With the enable bit clear, even a matching address is not acknowledged, and the status register stays 0.
- R3: The address byte 0x00 is acknowledged only when general-call enable (control bit 1) is set. It then sets status bits 6 and 0.
- R4: In a write transfer, each received byte is acknowledged, placed in the data register (address 4) and sets status bit 1.
- R5: While status bit 1 (byte received) or status bit 3 (byte wanted) is pending after an acknowledge bit, the clock line is held low. It is released once software clears that flag.
- R6: With forced-NACK (control bit 0) set, a received byte is answered with NACK but is still stored and flagged.
- R7: A matching address with the read bit set sets status bits 0, 3 and 5. Each byte is shifted out MSB first from the data register and then sets status bit 2. A controller ACK sets bit 3 again; a controller NACK does not.
- R8: A STOP after the block was addressed sets status bit 4 and clears status bit 5. A STOP after an unmatched address sets nothing.
- R9: Writing the status register (address 1) clears each flag written as 0 and leaves each flag written as 1 unchanged.
- R10: The interrupt output is high exactly when some status bit is set together with the same bit of the interrupt-enable register (address 2).
- R11: A repeated START during a transfer restarts the address phase, and a new direction takes effect.
- R12: Registers sit at control 0, status 1, interrupt-enable 2, own-address 3 and data 4, and all of them reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | Clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| scl_oe | output | 1 | Pull the clock line low |
| sda_oe | output | 1 | Pull the data line low |

## Verification
A wrong internal phase shows up at the ports within one bus bit. It appears as a missing or extra acknowledge on the data line, or as a clock line held low when no flag is pending. If the bit count or the shift register is wrong, a byte read back through the data register does not match, or the bits sampled by the bench controller during a read come out in the wrong order. If a status flag is set or cleared wrongly, the register read right after the acknowledge bit shows it, and so does the interrupt line in the same cycle.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int DW    = 8;
    localparam int AW    = 7;
    localparam int RA_W  = 3;
    localparam int CNT_W = $clog2(DW + 2);

    localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
    localparam logic [RA_W-1:0] RA_STAT = 3'd1;
    localparam logic [RA_W-1:0] RA_IEN  = 3'd2;
    localparam logic [RA_W-1:0] RA_OWN  = 3'd3;
    localparam logic [RA_W-1:0] RA_DATA = 3'd4;

    // field order equals bit order: bit 3 down to bit 0
    typedef struct packed {
        logic buf_sel;
        logic en;
        logic gce;
        logic fnak;
    } ctrl_t;

    // field order equals bit order: bit 6 down to bit 0
    typedef struct packed {
        logic gca;
        logic txm;
        logic stop;
        logic txe;
        logic txd;
        logic rxf;
        logic adr;
    } stat_t;

    localparam int SW = $bits(stat_t);

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } busev_t;

    typedef struct packed {
        logic adr;
        logic gca;
        logic rxf;
        logic txe;
        logic txd;
        logic stop;
        logic txm_set;
        logic txm_clr;
    } evt_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_RX, PH_ACK, PH_HOLD, PH_TX, PH_TACK
    } phase_t;

    function automatic logic addr_hit(input logic [DW-1:0] b,
                                      input logic [AW-1:0] own);
        return b[DW-1:1] == own;
    endfunction
endpackage

// File: rtl/i2ct_lines.sv
module i2ct_lines
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   scl_i,
    input  logic   sda_i,
    output busev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_p, sda_p, scl_s, sda_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  busev_t        ev,
    input  ctrl_t         ctrl,
    input  logic [AW-1:0] own,
    input  logic [DW-1:0] tx_byte,
    input  logic          rx_pend,
    input  logic          tx_pend,
    output evt_t          evt,
    output logic [DW-1:0] rx_byte,
    output logic          sda_oe,
    output logic          scl_oe
);
    phase_t             phase;
    logic [DW-1:0]      sh;
    logic [CNT_W-1:0]   cnt;
    logic               rw, sel, ack_en, mack;
    logic [DW-1:0]      byte_in;
    logic               gc_hit, hit, pend;

    assign byte_in = {sh[DW-2:0], ev.sda};
    assign gc_hit  = ctrl.gce && (byte_in == '0);
    assign hit     = ctrl.en && (addr_hit(byte_in, own) || gc_hit);
    assign pend    = rw ? tx_pend : rx_pend;
    assign scl_oe  = (phase == PH_HOLD) && pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            sh      <= '0;
            cnt     <= '0;
            rw      <= 1'b0;
            sel     <= 1'b0;
            ack_en  <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            rx_byte <= '0;
            evt     <= '0;
        end else begin
            evt <= '0;
            if (ev.stop) begin
                phase        <= PH_IDLE;
                sda_oe       <= 1'b0;
                sel          <= 1'b0;
                evt.stop     <= sel;
                evt.txm_clr  <= 1'b1;
            end else if (ev.start) begin
                phase        <= PH_ADDR;
                cnt          <= '0;
                sda_oe       <= 1'b0;
                sel          <= 1'b0;
                evt.txm_clr  <= 1'b1;
            end else begin
                case (phase)
                    PH_ADDR: if (ev.scl_rise) begin
                        sh  <= byte_in;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(DW-1)) begin
                            if (hit) begin
                                phase       <= PH_ACK;
                                rw          <= byte_in[0];
                                sel         <= 1'b1;
                                ack_en      <= 1'b1;
                                evt.adr     <= 1'b1;
                                evt.gca     <= gc_hit;
                                evt.txm_set <= byte_in[0];
                                evt.txe     <= byte_in[0];
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_RX: if (ev.scl_rise) begin
                        sh  <= byte_in;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(DW-1)) begin
                            rx_byte <= byte_in;
                            evt.rxf <= 1'b1;
                            ack_en  <= ~ctrl.fnak;
                            phase   <= PH_ACK;
                        end
                    end
                    PH_ACK: if (ev.scl_fall) begin
                        if (cnt == CNT_W'(DW)) begin
                            sda_oe <= ack_en;
                            cnt    <= CNT_W'(DW+1);
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= PH_HOLD;
                        end
                    end
                    PH_HOLD: if (!pend && !evt.txe && !evt.rxf) begin
                        cnt <= '0;
                        if (rw) begin
                            sh     <= tx_byte;
                            sda_oe <= ~tx_byte[DW-1];
                            phase  <= PH_TX;
                        end else begin
                            phase <= PH_RX;
                        end
                    end
                    PH_TX: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == CNT_W'(DW)) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_TACK;
                            end else begin
                                sh     <= {sh[DW-2:0], 1'b0};
                                sda_oe <= ~sh[DW-2];
                            end
                        end
                    end
                    PH_TACK: begin
                        if (ev.scl_rise) begin
                            mack    <= ~ev.sda;
                            evt.txd <= 1'b1;
                            cnt     <= CNT_W'(DW+1);
                        end else if (ev.scl_fall && cnt == CNT_W'(DW+1)) begin
                            if (mack) begin
                                evt.txe <= 1'b1;
                                phase   <= PH_HOLD;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_oe && phase == PH_IDLE)); // R8
    AST_DISABLED_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && phase == PH_ADDR && ev.scl_rise && cnt == CNT_W'(DW-1))
        |=> (phase == PH_IDLE && !evt.adr)); // R2
    AST_RESUME_TX: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && rw && !tx_pend && !evt.txe && !ev.start && !ev.stop)
        |=> (phase == PH_TX)); // R5
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
    import i2ct_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [RA_W-1:0] addr,
    input  logic [DW-1:0]   wdata,
    input  evt_t            evt,
    input  logic [DW-1:0]   rx_byte,
    output logic [DW-1:0]   rdata,
    output ctrl_t           ctrl,
    output logic [AW-1:0]   own,
    output logic [DW-1:0]   data,
    output stat_t           stat,
    output logic            irq
);
    stat_t ien, nxt;

    always_comb begin
        nxt = stat;
        if (wr && addr == RA_STAT) begin
            nxt     = stat & stat_t'(wdata[SW-1:0]);
            nxt.txm = stat.txm;
        end
        nxt.adr  = nxt.adr  | evt.adr;
        nxt.gca  = nxt.gca  | evt.gca;
        nxt.rxf  = nxt.rxf  | evt.rxf;
        nxt.txe  = nxt.txe  | evt.txe;
        nxt.txd  = nxt.txd  | evt.txd;
        nxt.stop = nxt.stop | evt.stop;
        if (evt.txm_set)      nxt.txm = 1'b1;
        else if (evt.txm_clr) nxt.txm = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            ien  <= '0;
            ctrl <= '0;
            own  <= '0;
            data <= '0;
        end else begin
            stat <= nxt;
            if (wr && addr == RA_CTRL) ctrl <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
            if (wr && addr == RA_IEN)  ien  <= stat_t'(wdata[SW-1:0]);
            if (wr && addr == RA_OWN)  own  <= wdata[AW-1:0];
            if (evt.rxf)                    data <= rx_byte;
            else if (wr && addr == RA_DATA) data <= wdata;
        end
    end

    always_comb begin
        case (addr)
            RA_CTRL: rdata = DW'(ctrl);
            RA_STAT: rdata = DW'(stat);
            RA_IEN:  rdata = DW'(ien);
            RA_OWN:  rdata = DW'(own);
            RA_DATA: rdata = data;
            default: rdata = '0;
        endcase
    end

    assign irq = |(stat & ien);

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == RA_STAT && !wdata[0] && !evt.adr) |=> !stat.adr); // R9
    AST_TXM_SET: assert property (@(posedge clk) disable iff (rst)
        evt.txm_set |=> stat.txm); // R7
endmodule

// File: rtl/i2ct_top.sv
module i2ct_top
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    busev_t        ev;
    evt_t          evt;
    ctrl_t         ctrl;
    stat_t         stat;
    logic [AW-1:0] own;
    logic [DW-1:0] data, rx_byte;

    i2ct_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2ct_engine u_engine (
        .clk(clk), .rst(rst), .ev(ev), .ctrl(ctrl), .own(own),
        .tx_byte(data), .rx_pend(stat.rxf), .tx_pend(stat.txe),
        .evt(evt), .rx_byte(rx_byte), .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    i2ct_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .evt(evt), .rx_byte(rx_byte),
        .rdata(reg_rdata), .ctrl(ctrl), .own(own), .data(data),
        .stat(stat), .irq(irq)
    );
endmodule

// File: tb/test_i2ct_top.sv
module test_i2ct_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
    logic scl_line, sda_line;
    int n_run = 0, n_fail = 0;
    logic [7:0] mdl_stat;   // behavioural model of the status register
    logic [7:0] mdl_ien;
    logic [7:0] rd;
    logic ackb;

    assign scl_line = ~(m_scl_lo | scl_oe);
    assign sda_line = ~(m_sda_lo | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2ct_top i_i2ct_top (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 3'd1) mdl_stat = mdl_stat & (d | 8'h20);
        if (a == 3'd2) mdl_ien = d;
    endtask

    task automatic rrd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic stat_chk(input string tag);
        logic [7:0] s;
        rrd(3'd1, s);
        chk(tag, s, mdl_stat);
    endtask

    task automatic m_start();
        m_sda_lo = 1'b1; wclk(Q);
        m_scl_lo = 1'b1; wclk(Q);
    endtask

    task automatic m_rstart();
        m_sda_lo = 1'b0; wclk(Q);
        m_scl_lo = 1'b0;
        while (!scl_line) @(negedge clk);
        wclk(Q);
        m_sda_lo = 1'b1; wclk(Q);
        m_scl_lo = 1'b1; wclk(Q);
    endtask

    task automatic m_stop();
        m_sda_lo = 1'b1; wclk(Q);
        m_scl_lo = 1'b0;
        while (!scl_line) @(negedge clk);
        wclk(Q);
        m_sda_lo = 1'b0; wclk(Q);
    endtask

    task automatic m_wbit(input logic b);
        m_sda_lo = ~b; wclk(Q);
        m_scl_lo = 1'b0;
        while (!scl_line) @(negedge clk);
        wclk(Q);
        m_scl_lo = 1'b1; wclk(Q);
    endtask

    task automatic m_rbit(output logic b);
        m_sda_lo = 1'b0; wclk(Q);
        m_scl_lo = 1'b0;
        while (!scl_line) @(negedge clk);
        wclk(Q/2);
        b = sda_line;
        wclk(Q/2);
        m_scl_lo = 1'b1; wclk(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic a);
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(a);
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_rbit(v[i]);
        m_wbit(~give_ack);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        mdl_stat = 8'h00;
        mdl_ien  = 8'h00;
        wclk(4);
        rst = 1'b0;
        wclk(2);
        // R12: reset values
        rrd(3'd0, rd); chk("R12 ctrl reset", rd, 8'h00);
        rrd(3'd3, rd); chk("R12 own reset", rd, 8'h00);
        stat_chk("R12 status reset");
        chk("R10 irq reset", irq, 0);
        chk("R5 scl_oe reset", scl_oe, 0);

        rwr(3'd3, 8'h2A);
        rrd(3'd3, rd); chk("R12 own readback", rd, 8'h2A);

        // R2: disabled block ignores its own address
        m_start(); m_wbyte(8'h54, ackb); m_stop();
        chk("R2 nack while disabled", ackb, 1);
        stat_chk("R2 status stays 0");

        rwr(3'd0, 8'h04);
        // R1: mismatching address
        m_start(); m_wbyte(8'h56, ackb); m_stop();
        chk("R1 nack on mismatch", ackb, 1);
        stat_chk("R1/R8 no flag on mismatch");

        // R1/R4/R5/R9: write transfer
        m_start(); m_wbyte(8'h54, ackb);
        chk("R1 ack on match", ackb, 0);
        mdl_stat = 8'h01;
        stat_chk("R1 address flag");
        m_wbyte(8'hA5, ackb);
        chk("R4 ack on data", ackb, 0);
        mdl_stat = 8'h03;
        stat_chk("R4 rx flag");
        rrd(3'd4, rd); chk("R4 data byte", rd, 8'hA5);
        wclk(3);
        chk("R5 clock held while rx pending", scl_oe, 1);
        chk("R10 irq low while disabled", irq, 0);
        rwr(3'd1, 8'hFD);
        stat_chk("R9 clear only rx flag");
        wclk(3);
        chk("R5 clock released", scl_oe, 0);
        rwr(3'd1, 8'hFE);
        stat_chk("R9 clear address flag");
        m_wbyte(8'h3C, ackb);
        mdl_stat = mdl_stat | 8'h02;
        rrd(3'd4, rd); chk("R4 second byte", rd, 8'h3C);
        rwr(3'd1, 8'hFD);
        // R6: forced NACK
        rwr(3'd0, 8'h05);
        m_wbyte(8'h77, ackb);
        mdl_stat = mdl_stat | 8'h02;
        chk("R6 forced nack", ackb, 1);
        rrd(3'd4, rd); chk("R6 byte still stored", rd, 8'h77);
        rwr(3'd1, 8'hFD);
        rwr(3'd0, 8'h04);
        // R10: interrupt on stop
        rwr(3'd2, 8'h10);
        m_stop();
        mdl_stat = mdl_stat | 8'h10;
        stat_chk("R8 stop flag");
        chk("R10 irq on enabled flag", irq, ((mdl_stat & mdl_ien) != 0) ? 1 : 0);
        rwr(3'd1, 8'hEF);
        chk("R10 irq drops after clear", irq, 0);
        rwr(3'd2, 8'h00);

        // R7: read transfer
        m_start(); m_wbyte(8'h55, ackb);
        chk("R7 ack on read address", ackb, 0);
        mdl_stat = 8'h29;
        stat_chk("R7 read address flags");
        wclk(2);
        chk("R5 clock held while tx wanted", scl_oe, 1);
        rwr(3'd4, 8'hC3);
        rwr(3'd1, 8'hF6);
        m_rbyte(1'b1, rd);
        chk("R7 first byte msb first", rd, 8'hC3);
        mdl_stat = mdl_stat | 8'h0C;
        stat_chk("R7 sent and wanted flags");
        rwr(3'd4, 8'h5A);
        rwr(3'd1, 8'hF3);
        m_rbyte(1'b0, rd);
        chk("R7 second byte", rd, 8'h5A);
        mdl_stat = mdl_stat | 8'h04;
        stat_chk("R7 no request after nack");
        m_stop();
        mdl_stat = (mdl_stat | 8'h10) & 8'hDF;
        stat_chk("R8 stop clears transmit mode");
        rwr(3'd1, 8'h00);
        mdl_stat = 8'h00;

        // R3: general call
        m_start(); m_wbyte(8'h00, ackb); m_stop();
        chk("R3 nack general call disabled", ackb, 1);
        stat_chk("R3 no flag");
        rwr(3'd0, 8'h06);
        m_start(); m_wbyte(8'h00, ackb);
        chk("R3 ack general call", ackb, 0);
        mdl_stat = 8'h41;
        stat_chk("R3 general call flags");
        m_stop();
        rwr(3'd1, 8'h00);
        mdl_stat = 8'h00;

        // R11: repeated start switches direction
        m_start(); m_wbyte(8'h54, ackb);
        rwr(3'd1, 8'h00);
        mdl_stat = 8'h00;
        m_rstart(); m_wbyte(8'h55, ackb);
        chk("R11 ack after repeated start", ackb, 0);
        mdl_stat = 8'h29;
        stat_chk("R11 read flags after repeated start");
        rwr(3'd4, 8'h81);
        rwr(3'd1, 8'hF6);
        m_rbyte(1'b0, rd);
        chk("R11 byte after repeated start", rd, 8'h81);
        m_stop();

        wclk(4);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule